// File: doc/BRIEF.md
# Memory Controller Halt Sequencer

This block moves a DDR SDRAM controller into and out of a low-power halt state. There are two ways in. Software can set a halt bit. The block can also halt by itself after the memory ports have been idle for a programmed number of cycles, but only when automatic halting is enabled. Both paths use the same self-refresh handshake with the command scheduler. The block raises a one-state enter or exit command and holds it until the scheduler acknowledges it.

While the controller is halted, the DRAM sits in self-refresh. Every request port is back-pressured whenever the sequencer is not in its running state. An automatic halt ends on its own as soon as any port presents a request. A manual halt ends only when software clears the bit.

A settle counter starts each time the halted state is entered. It raises a flag once enough controller cycles have passed that the clock may be retuned or stopped.

Top module: `mem_halt_seq`

## Requirements
- R1: After reset the block is running. `req_ready` is all ones, and `sr_enter`, `sr_exit`, `halt_status` and `clk_change_ok` are 0.
- R2: When `cfg_halt_req` is 1 in the running state, `sr_enter` rises at the next clock edge. Once `sched_ack` is sampled high during enter, `halt_status` rises at the following edge.
- R3: In a manual halt, requests do not wake the block. Clearing `cfg_halt_req` raises `sr_exit` at the next edge. An acknowledge then returns the block to running.
- R4: With `cfg_auto_en` = 1 and limit N, `sr_enter` rises at the edge that closes the (N+1)th consecutive idle running cycle. An idle cycle is one with no `req_valid` bit and no `cmd_busy`. With `cfg_auto_en` = 0, idle time never starts a halt.
- R5: Any cycle with a valid request or `cmd_busy` = 1 restarts the idle count from N.
- R6: In an automatic halt with `cfg_halt_req` = 0, any `req_valid` bit raises `sr_exit` at the next edge.
- R7: If `cfg_halt_req` is set during an automatic halt, requests no longer wake the block. Only clearing the bit ends that halt.
- R8: `req_ready` is all zeros in every state other than running, including enter, halted and exit.
- R9: `clk_change_ok` rises exactly SETTLE_CYCLES edges after `halt_status` rises. It is 0 outside the halted state. Its count starts over on every entry to halted.
- R10: The enter and exit states hold their command output for as long as `sched_ack` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_halt_req | input | 1 | Software halt bit: 1 requests halt, 0 requests leaving halt |
| cfg_auto_en | input | 1 | Enables idle-timeout halting |
| cfg_idle_limit | input | CNT_W | Idle cycle count before an automatic halt |
| req_valid | input | NUM_PORTS | Request-valid flag per memory port |
| cmd_busy | input | 1 | A DRAM command is still in flight |
| req_ready | output | NUM_PORTS | Per-port ready, low while not running |
| sr_enter | output | 1 | Self-refresh enter command to the scheduler |
| sr_exit | output | 1 | Self-refresh exit command to the scheduler |
| sched_ack | input | 1 | Scheduler acknowledge for enter or exit |
| halt_status | output | 1 | High while in the halted state |
| clk_change_ok | output | 1 | Clock may be changed or stopped |

## Verification
The bench builds the block with three request ports, an 8-bit idle count and the full 256-cycle settle interval. Idle limits of 0, 5 and 10 let it cover the zero-limit case, a countdown interrupted by a busy command, and a plain countdown, all within a few dozen cycles. Keeping the settle interval at its real length lets the bench check that a short automatic halt never raises the clock flag, and that a later halt measures its own full interval from the beginning.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_ENTER   = 2'd1,
        ST_HALTED  = 2'd2,
        ST_EXIT    = 2'd3
    } hsq_state_e;

    typedef struct packed {
        logic running;
        logic sr_enter;
        logic halted;
        logic sr_exit;
    } hsq_ctrl_t;

    function automatic hsq_ctrl_t hsq_decode(input hsq_state_e st);
        hsq_ctrl_t c;
        c.running  = (st == ST_RUN);
        c.sr_enter = (st == ST_ENTER);
        c.halted   = (st == ST_HALTED);
        c.sr_exit  = (st == ST_EXIT);
        return c;
    endfunction

    function automatic logic hsq_may_wake(input logic halt_bit,
                                          input logic manual_cause,
                                          input logic any_req);
        return !halt_bit && (manual_cause || any_req);
    endfunction

endpackage

// File: rtl/hsq_idle_timer.sv
module hsq_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             activity_i,
    input  logic             running_i,
    input  logic             auto_en_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] remain_q;
    logic             reload;
    logic             at_zero;

    assign reload  = activity_i || !running_i || !auto_en_i;
    assign at_zero = (remain_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= limit_i;
        end else if (reload) begin
            remain_q <= limit_i;
        end else if (!at_zero) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired_o = running_i && auto_en_i && !activity_i && at_zero;

    // Activity in one cycle leaves the count at the limit for the next cycle.
    AST_IDLE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        activity_i |=> (remain_q == $past(limit_i)))
        else $error("idle count not reloaded");  // R5

endmodule

// File: rtl/hsq_settle_timer.sv
module hsq_settle_timer #(
    parameter int SETTLE_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic halted_i,
    output logic settled_o
);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] LAST = SW'(SETTLE_CYCLES);

    logic [SW-1:0] age_q;
    logic          full;

    assign full = (age_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !halted_i) begin
            age_q <= '0;
        end else if (!full) begin
            age_q <= age_q + 1'b1;
        end
    end

    assign settled_o = halted_i && full;

    AST_SETTLE_RESTART: assert property (@(posedge clk) disable iff (rst)
        !halted_i |=> (age_q == '0))
        else $error("settle count kept across exit");  // R9

endmodule

// File: rtl/hsq_fsm.sv
module hsq_fsm
    import hsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_req_i,
    input  logic       auto_expired_i,
    input  logic       any_req_i,
    input  logic       ack_i,
    output hsq_state_e state_o,
    output hsq_ctrl_t  ctrl_o
);
    hsq_state_e state_q, state_d;
    logic       manual_q, manual_d;

    always_comb begin
        state_d  = state_q;
        manual_d = manual_q;
        unique case (state_q)
            ST_RUN: begin
                if (halt_req_i) begin
                    state_d  = ST_ENTER;
                    manual_d = 1'b1;
                end else if (auto_expired_i) begin
                    state_d  = ST_ENTER;
                    manual_d = 1'b0;
                end
            end
            ST_ENTER: begin
                if (halt_req_i) manual_d = 1'b1;
                if (ack_i) state_d = ST_HALTED;
            end
            ST_HALTED: begin
                if (halt_req_i) manual_d = 1'b1;
                if (hsq_may_wake(halt_req_i, manual_q, any_req_i))
                    state_d = ST_EXIT;
            end
            ST_EXIT: begin
                if (ack_i) begin
                    state_d  = ST_RUN;
                    manual_d = 1'b0;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            manual_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            manual_q <= manual_d;
        end
    end

    assign state_o = state_q;
    assign ctrl_o  = hsq_decode(state_q);

    AST_ENTER_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ENTER && !ack_i) |=> (state_q == ST_ENTER))
        else $error("enter left without ack");  // R10

    AST_EXIT_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXIT && !ack_i) |=> (state_q == ST_EXIT))
        else $error("exit left without ack");  // R10

    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALTED && halt_req_i) |=> (state_q == ST_HALTED))
        else $error("halt left while bit set");  // R7

    AST_MANUAL_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALTED && manual_q && halt_req_i && any_req_i)
            |=> (state_q == ST_HALTED))
        else $error("manual halt woken by request");  // R3

endmodule

// File: rtl/mem_halt_seq.sv
module mem_halt_seq
    import hsq_pkg::*;
#(
    parameter int NUM_PORTS     = 4,
    parameter int CNT_W         = 16,
    parameter int SETTLE_CYCLES = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_halt_req,
    input  logic                 cfg_auto_en,
    input  logic [CNT_W-1:0]     cfg_idle_limit,
    input  logic [NUM_PORTS-1:0] req_valid,
    input  logic                 cmd_busy,
    output logic [NUM_PORTS-1:0] req_ready,
    output logic                 sr_enter,
    output logic                 sr_exit,
    input  logic                 sched_ack,
    output logic                 halt_status,
    output logic                 clk_change_ok
);
    hsq_state_e state;
    hsq_ctrl_t  ctrl;
    logic       any_req;
    logic       idle_expired;
    logic       settled;

    assign any_req = |req_valid;

    hsq_idle_timer #(.CNT_W(CNT_W)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .activity_i (any_req || cmd_busy),
        .running_i  (ctrl.running),
        .auto_en_i  (cfg_auto_en),
        .limit_i    (cfg_idle_limit),
        .expired_o  (idle_expired)
    );

    hsq_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .halt_req_i     (cfg_halt_req),
        .auto_expired_i (idle_expired),
        .any_req_i      (any_req),
        .ack_i          (sched_ack),
        .state_o        (state),
        .ctrl_o         (ctrl)
    );

    hsq_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk       (clk),
        .rst       (rst),
        .halted_i  (ctrl.halted),
        .settled_o (settled)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ready
        assign req_ready[p] = ctrl.running;
    end

    assign sr_enter      = ctrl.sr_enter;
    assign sr_exit       = ctrl.sr_exit;
    assign halt_status   = ctrl.halted;
    assign clk_change_ok = settled;

    AST_NO_READY_HALTED: assert property (@(posedge clk) disable iff (rst)
        (sr_enter || halt_status || sr_exit) |-> (req_ready == '0))
        else $error("ready while not running");  // R8

    AST_OK_ONLY_HALTED: assert property (@(posedge clk) disable iff (rst)
        clk_change_ok |-> halt_status)
        else $error("clock flag outside halt");  // R9

    AST_OK_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_status) |-> !clk_change_ok)
        else $error("clock flag at halt entry");  // R9

    AST_AUTO_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && idle_expired) |=> sr_enter)
        else $error("expired idle count did not halt");  // R4

    AST_BUSY_NO_AUTO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !cfg_halt_req && (any_req || cmd_busy)) |=> !sr_enter)
        else $error("halted while active");  // R5

    AST_WAKE: assert property (@(posedge clk) disable iff (rst)
        (halt_status && !cfg_halt_req && any_req) |=> sr_exit)
        else $error("request did not wake");  // R6

endmodule

// File: tb/mem_halt_seq_tb.sv
`timescale 1ns/1ps
module mem_halt_seq_tb;
    localparam int NP = 3;
    localparam int CW = 8;
    localparam int ST = 256;

    localparam int EV_ENTER = 0;
    localparam int EV_HALT  = 1;
    localparam int EV_OK    = 2;
    localparam int EV_EXIT  = 3;
    localparam int EV_RUN   = 4;

    typedef struct {
        int    kind;
        int    at;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_halt_req = 1'b0;
    logic          cfg_auto_en = 1'b0;
    logic [CW-1:0] cfg_idle_limit = 8'd10;
    logic [NP-1:0] req_valid = '0;
    logic          cmd_busy = 1'b0;
    logic          sched_ack = 1'b0;
    logic [NP-1:0] req_ready;
    logic          sr_enter, sr_exit, halt_status, clk_change_ok;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;
    exp_t sb[$];

    mem_halt_seq #(.NUM_PORTS(NP), .CNT_W(CW), .SETTLE_CYCLES(ST)) u_dut (
        .clk(clk), .rst(rst), .cfg_halt_req(cfg_halt_req), .cfg_auto_en(cfg_auto_en),
        .cfg_idle_limit(cfg_idle_limit), .req_valid(req_valid), .cmd_busy(cmd_busy),
        .req_ready(req_ready), .sr_enter(sr_enter), .sr_exit(sr_exit),
        .sched_ack(sched_ack), .halt_status(halt_status), .clk_change_ok(clk_change_ok)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_ev(input int kind, input int at, input string tag);
        exp_t e;
        e.kind = kind; e.at = at; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Pulse the scheduler acknowledge for one cycle; returns the cycle it was driven in.
    task automatic ack_pulse(output int at);
        at = cyc;
        sched_ack = 1'b1;
        tick();
        sched_ack = 1'b0;
    endtask

    // Monitor: pops expected events as rising edges are seen.
    initial begin
        logic [4:0] prev = '0;
        logic [4:0] cur;
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            cur = {req_ready[0], sr_exit, clk_change_ok, halt_status, sr_enter};
            if (mon_en) begin
                for (int k = 0; k < 5; k++) begin
                    if (cur[k] && !prev[k]) begin
                        checks++;
                        if (sb.size() == 0) begin
                            errors++;
                            $display("FAIL R2/R4/R6/R9: unexpected event kind=%0d at %0d, expected none",
                                     k, cyc);
                        end else begin
                            e = sb.pop_front();
                            if (e.kind != k || e.at != cyc) begin
                                errors++;
                                $display("FAIL %s: actual kind=%0d at %0d expected kind=%0d at %0d",
                                         e.tag, k, cyc, e.kind, e.at);
                            end
                        end
                    end
                end
            end
            prev = cur;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c, a, b, d, w;
        tick(3);
        rst = 1'b0;
        tick();
        mon_en = 1'b1;

        // R1 reset state
        chk(req_ready == 3'b111, "R1 ready", int'(req_ready), 7);
        chk(!sr_enter && !sr_exit, "R1 commands", int'({sr_enter, sr_exit}), 0);
        chk(!halt_status && !clk_change_ok, "R1 status", int'({halt_status, clk_change_ok}), 0);

        // Manual halt: R2, R10, R8, R3, R9
        c = cyc;
        cfg_halt_req = 1'b1;
        expect_ev(EV_ENTER, c + 1, "R2 enter");
        tick(4);
        chk(sr_enter == 1'b1, "R10 enter held", int'(sr_enter), 1);
        chk(req_ready == '0, "R8 ready in enter", int'(req_ready), 0);
        expect_ev(EV_HALT, cyc + 1, "R2 halted");
        expect_ev(EV_OK, cyc + 1 + ST, "R9 settle");
        ack_pulse(a);
        req_valid = 3'b010;
        tick(5);
        chk(halt_status == 1'b1, "R3 request ignored", int'(halt_status), 1);
        chk(req_ready == '0, "R8 ready halted", int'(req_ready), 0);
        req_valid = '0;
        tick(300);
        chk(clk_change_ok == 1'b1, "R9 flag held", int'(clk_change_ok), 1);
        b = cyc;
        cfg_halt_req = 1'b0;
        expect_ev(EV_EXIT, b + 1, "R3 exit");
        tick(3);
        chk(sr_exit == 1'b1, "R10 exit held", int'(sr_exit), 1);
        chk(clk_change_ok == 1'b0, "R9 flag off", int'(clk_change_ok), 0);
        expect_ev(EV_RUN, cyc + 1, "R3 running");
        ack_pulse(d);
        chk(req_ready == 3'b111, "R3 ready back", int'(req_ready), 7);

        // Auto disabled: R4
        tick(40);
        chk(!sr_enter && req_ready == 3'b111, "R4 no auto halt", int'(sr_enter), 0);

        // Auto timing, limit 10: R4, R6
        cfg_idle_limit = 8'd10;
        cfg_auto_en = 1'b1;
        req_valid = 3'b001;
        tick();
        c = cyc;
        req_valid = '0;
        expect_ev(EV_ENTER, c + 11, "R4 idle entry");
        tick(14);
        expect_ev(EV_HALT, cyc + 1, "R6 halted");
        ack_pulse(a);
        tick(20);
        w = cyc;
        req_valid = 3'b100;
        expect_ev(EV_EXIT, w + 1, "R6 wake");
        tick(2);
        chk(req_ready == '0, "R8 ready in exit", int'(req_ready), 0);
        expect_ev(EV_RUN, cyc + 1, "R6 running");
        ack_pulse(d);
        cfg_auto_en = 1'b0;
        req_valid = '0;
        tick(2);

        // Busy reload, limit 5: R5, R9 restart, then R7 override
        cfg_idle_limit = 8'd5;
        cfg_auto_en = 1'b1;
        req_valid = 3'b001;
        tick();
        c = cyc;
        req_valid = '0;
        tick(3);
        cmd_busy = 1'b1;
        tick();
        cmd_busy = 1'b0;
        expect_ev(EV_ENTER, c + 10, "R5 busy reload");
        tick(8);
        expect_ev(EV_HALT, cyc + 1, "R5 halted");
        expect_ev(EV_OK, cyc + 1 + ST, "R9 settle restart");
        ack_pulse(a);
        tick(5);
        cfg_halt_req = 1'b1;
        tick();
        req_valid = 3'b001;
        tick(10);
        chk(halt_status == 1'b1, "R7 override holds", int'(halt_status), 1);
        chk(!sr_exit, "R7 no exit", int'(sr_exit), 0);
        tick(260);
        b = cyc;
        cfg_halt_req = 1'b0;
        expect_ev(EV_EXIT, b + 1, "R7 exit on clear");
        tick(2);
        expect_ev(EV_RUN, cyc + 1, "R7 running");
        ack_pulse(d);
        cfg_auto_en = 1'b0;
        req_valid = '0;
        tick(2);

        // Zero limit: R4
        cfg_idle_limit = 8'd0;
        cfg_auto_en = 1'b1;
        req_valid = 3'b010;
        tick();
        c = cyc;
        req_valid = '0;
        expect_ev(EV_ENTER, c + 1, "R4 zero limit");
        tick(2);
        expect_ev(EV_HALT, cyc + 1, "R4 zero halted");
        ack_pulse(a);
        tick(3);
        w = cyc;
        req_valid = 3'b001;
        expect_ev(EV_EXIT, w + 1, "R6 zero wake");
        tick(2);
        expect_ev(EV_RUN, cyc + 1, "R6 zero running");
        cfg_auto_en = 1'b0;
        ack_pulse(d);
        req_valid = '0;
        tick(5);

        chk(sb.size() == 0, "R2/R9 all events seen", sb.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule